// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in-first-out buffer for 9-bit words. A writer and a reader run on unrelated clocks. Each side qualifies its transfers with a clocked enable. Status comes out as empty, full, half-full, almost-empty and almost-full. The two "almost" thresholds are held in offset registers. A master reset fills those registers with one of two preset values. After that they can be reprogrammed in parallel through the data bus or serially, one bit per write clock. Pointers cross between domains as Gray codes through two-flop synchronizers. Full, half-full and almost-full are decided on the write side. Empty and almost-empty are decided on the read side.

Two read timings are available, chosen by a mode input that is sampled during master reset. In standard mode, a read enable moves the next word into the output register. The read status output then means "empty" and the write status output means "full". In fall-through mode, the head word is moved to the output on its own. The read status output then means "output word valid" and the write status output means "input ready". The output register then adds one word of capacity. A partial reset empties the buffer and keeps the offsets and the mode. Retransmit rewinds the reader to the first word written since the last reset, so the same data can be read again.

Depth is 2**ADDR_W words. For example, ADDR_W = 14 gives 16384 words and ADDR_W = 15 gives 32768 words. The storage is an inferred simple dual-port RAM whose registered read port is the output register. Both reset inputs may be asynchronous to either clock. They are synchronized into each domain and must be held for at least four cycles of the slower clock.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: Words leave in the order they were written. In standard mode, a read enable while not empty puts the next word on `dout` at that read-clock edge.
- R2: In standard mode, `rd_stat` is 1 exactly when no word is stored. A read enable while empty is ignored: `dout` and the read position do not change.
- R3: In standard mode, `wr_stat` is 1 exactly when DEPTH words are in the RAM. A write while full is ignored and is never read out.
- R4: `half_full` is 1 when more than DEPTH/2 words occupy the RAM.
- R5: `almost_empty` is 1 when the readable word count is at most the empty offset. In fall-through mode, the readable count includes the word held on `dout`.
- R6: `almost_full` is 1 when the RAM occupancy is at least DEPTH minus the full offset.
- R7: On master reset, both offsets are loaded with PRESET_LO if `thr_sel` is 0, or with PRESET_HI if `thr_sel` is 1.
- R8: While `load` is 1, a write enable stores `din` into the offsets instead of the buffer. The first such write sets the empty offset and the next sets the full offset; the sequence repeats, with bits taken from the low bits of `din` (wider offsets take several words each, low word first).
- R9: While `load` is 1, `wen` is 0 and `ser_en` is 1, one bit of `ser_in` is shifted in per write clock. All bits of the empty offset come first, then the full offset, each LSB first.
- R10: With `fwft_sel` = 1 at master reset, the head word appears on `dout` without a read enable. `rd_stat` means "output valid" and `wr_stat` means "input ready". The capacity becomes DEPTH+1 words. The word and flag hold while no read enable is given.
- R11: A partial reset empties the buffer but keeps both offsets and the timing mode.
- R12: A master reset empties the buffer and clears `dout` to 0.
- R13: A one-cycle `rt` rewinds reading to the first word written since the last reset. It is valid with the writer idle and fewer than DEPTH writes since that reset. In fall-through mode, that word is on `dout` one read clock after the `rt` edge.
- R14: A word written into an empty buffer becomes visible at the second read-clock edge after the write edge in standard mode (`rd_stat` falls), or at the third in fall-through mode (`rd_stat` rises).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high |
| prst | input | 1 | Partial reset, active high |
| fwft_sel | input | 1 | Timing mode, sampled in master reset (1 = fall-through) |
| thr_sel | input | 1 | Offset preset select, sampled in master reset |
| wen | input | 1 | Write enable |
| din | input | DATA_W | Write data, or offset word while loading |
| load | input | 1 | Offset load control |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset data bit |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request |
| dout | output | DATA_W | Read data register |
| wr_stat | output | 1 | Full (standard) or input ready (fall-through) |
| rd_stat | output | 1 | Empty (standard) or output valid (fall-through) |
| half_full | output | 1 | More than half of the RAM occupied |
| almost_full | output | 1 | Programmable almost-full |
| almost_empty | output | 1 | Programmable almost-empty |

## Verification
A wrong pointer or a bad Gray crossing shows at the ports as a flag that disagrees with the fill level. After both synchronizers settle, that disagreement is visible within a few cycles of either clock, and a misplaced word shows as a wrong value on `dout` at the very next read. The bench therefore steps the fill level one word at a time from empty to full and back, in both timing modes and under several offset settings. At each step it compares every flag against arithmetic on the count. A broken offset load, preset or partial reset moves the almost-empty or almost-full boundary by at least one word, so a sweep catches it at the step where the flag should toggle. Latency faults show as a flag change one read edge early or late, measured directly after a single write.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  parameter int DCF_DATA_W = 9;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port doubles as the block's output register
  always_ff @(posedge rclk) begin
    if (rrst)    q <= '0;
    else if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl import dcf_pkg::*; #(
  parameter int AW      = 8,
  parameter int DW      = 9,
  parameter int PRE_LO  = 7,
  parameter int PRE_HI  = 63
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          thr_sel,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          load,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic [AW:0]   rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic          wr_stat,
  output logic          half_full,
  output logic          almost_full
);

  localparam int PW      = AW + 1;
  localparam int OFF_W   = AW;
  localparam int NSEG    = (OFF_W + DW - 1) / DW;
  localparam int GW      = (2 * NSEG > 1) ? $clog2(2 * NSEG) : 1;
  localparam int SW      = $clog2(2 * OFF_W);
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  logic          wrst;
  rd_mode_e      mode_w;
  logic [PW-1:0] wbin, wbin_nxt, rbin_s, count_w;
  logic          full;
  logic [GW-1:0] seg;
  logic [SW-1:0] sidx;

  assign wrst     = mrst | prst;
  assign rbin_s   = PW'(from_gray(32'(rgray_s)));
  assign count_w  = wbin - rbin_s;
  assign full     = (count_w == DEPTH_P);
  assign mem_we   = wen && !load && !full && !wrst;
  assign wbin_nxt = wbin + PW'(1);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (mrst) mode_w <= rd_mode_e'(fwft_sel);
  end

  always_ff @(posedge clk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (mem_we) begin
      wbin  <= wbin_nxt;
      wgray <= PW'(to_gray(32'(wbin_nxt)));
    end
  end

  // offset registers: presets at master reset, parallel or serial loads after
  always_ff @(posedge clk) begin
    if (mrst) begin
      ae_off <= thr_sel ? OFF_W'(PRE_HI) : OFF_W'(PRE_LO);
      af_off <= thr_sel ? OFF_W'(PRE_HI) : OFF_W'(PRE_LO);
      seg    <= '0;
      sidx   <= '0;
    end else if (prst) begin
      seg    <= '0;
      sidx   <= '0;
    end else if (load && wen) begin
      for (int b = 0; b < OFF_W; b++) begin
        if (seg == GW'(b / DW))        ae_off[b] <= din[b % DW];
        if (seg == GW'(NSEG + b / DW)) af_off[b] <= din[b % DW];
      end
      seg <= (seg == GW'(2 * NSEG - 1)) ? '0 : seg + GW'(1);
    end else if (load && ser_en) begin
      for (int b = 0; b < OFF_W; b++) begin
        if (sidx == SW'(b))         ae_off[b] <= ser_in;
        if (sidx == SW'(b + OFF_W)) af_off[b] <= ser_in;
      end
      sidx <= (sidx == SW'(2 * OFF_W - 1)) ? '0 : sidx + SW'(1);
    end
  end

  assign wr_stat     = (mode_w == MODE_FWFT) ? !full : full;
  assign half_full   = count_w > (DEPTH_P >> 1);
  assign almost_full = count_w >= (DEPTH_P - {1'b0, af_off});

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (wrst) count_w <= DEPTH_P) else $error("write count above depth"); // R3
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (wrst) full |=> (wbin == $past(wbin))) else $error("write accepted while full"); // R3
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (wrst) load |=> (wbin == $past(wbin))) else $error("data written during offset load"); // R8
  AST_PARTIAL_KEEPS_OFFSETS: assert property (@(posedge clk) disable iff (mrst) prst |=> (ae_off == $past(ae_off) && af_off == $past(af_off))) else $error("partial reset altered offsets"); // R11

endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl import dcf_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          ren,
  input  logic          rt,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  output logic          mem_re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          fwft_mode,
  output logic          rd_stat,
  output logic          almost_empty
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  logic          rrst;
  rd_mode_e      mode_r;
  logic [PW-1:0] rbin, rbin_nxt, wbin_s, mem_cnt, words;
  logic          mem_empty, out_vld;

  assign rrst      = mrst | prst;
  assign wbin_s    = PW'(from_gray(32'(wgray_s)));
  assign mem_cnt   = wbin_s - rbin;
  assign mem_empty = (mem_cnt == '0);
  assign fwft_mode = (mode_r == MODE_FWFT);
  assign raddr     = rbin[AW-1:0];

  always_comb begin
    if (rrst || rt)     mem_re = 1'b0;
    else if (fwft_mode) mem_re = !mem_empty && (!out_vld || ren);
    else                mem_re = ren && !mem_empty;
  end

  assign rbin_nxt = rt ? '0 : (mem_re ? rbin + PW'(1) : rbin);

  always_ff @(posedge clk) begin
    if (mrst) mode_r <= rd_mode_e'(fwft_sel);
  end

  always_ff @(posedge clk) begin
    if (rrst) begin
      rbin    <= '0;
      rgray   <= '0;
      out_vld <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= PW'(to_gray(32'(rbin_nxt)));
      if (rt)          out_vld <= 1'b0;
      else if (mem_re) out_vld <= fwft_mode;
      else if (ren)    out_vld <= 1'b0;
    end
  end

  assign words        = mem_cnt + PW'(out_vld);
  assign rd_stat      = fwft_mode ? out_vld : mem_empty;
  assign almost_empty = words <= {1'b0, ae_off};

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rrst) mem_cnt <= DEPTH_P) else $error("read passed write pointer"); // R2
  AST_EMPTY_HOLDS_PTR: assert property (@(posedge clk) disable iff (rrst) (mem_empty && !rt) |=> (rbin == $past(rbin))) else $error("read pointer moved while empty"); // R2
  AST_RT_REWINDS: assert property (@(posedge clk) disable iff (rrst) rt |=> (rbin == '0 && !out_vld)) else $error("retransmit did not rewind"); // R13

endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo import dcf_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = DCF_DATA_W,
  parameter int PRESET_LO = 7,
  parameter int PRESET_HI = 63
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwft_sel,
  input  logic              thr_sel,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  input  logic              load,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic              ren,
  input  logic              rt,
  output logic [DATA_W-1:0] dout,
  output logic              wr_stat,
  output logic              rd_stat,
  output logic              half_full,
  output logic              almost_full,
  output logic              almost_empty
);

  localparam int PW = ADDR_W + 1;

  logic [1:0]        rst_w, rst_r;
  logic [PW-1:0]     wgray, rgray, wgray_r, rgray_w;
  logic              mem_we, mem_re, fwft_r;
  logic [ADDR_W-1:0] waddr, raddr, ae_off, af_off;

  // reset inputs brought into each clock domain
  dcf_sync #(.W(2)) u_rst_w (.clk(wclk), .rst(1'b0), .d({mrst, prst}), .q(rst_w));
  dcf_sync #(.W(2)) u_rst_r (.clk(rclk), .rst(1'b0), .d({mrst, prst}), .q(rst_r));

  // Gray pointer crossings
  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst_r[1] | rst_r[0]), .d(wgray), .q(wgray_r));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst_w[1] | rst_w[0]), .d(rgray), .q(rgray_w));

  dcf_wr_ctrl #(
    .AW(ADDR_W), .DW(DATA_W), .PRE_LO(PRESET_LO), .PRE_HI(PRESET_HI)
  ) u_wr (
    .clk(wclk), .mrst(rst_w[1]), .prst(rst_w[0]),
    .fwft_sel(fwft_sel), .thr_sel(thr_sel),
    .wen(wen), .din(din), .load(load), .ser_en(ser_en), .ser_in(ser_in),
    .rgray_s(rgray_w),
    .mem_we(mem_we), .waddr(waddr), .wgray(wgray),
    .ae_off(ae_off), .af_off(af_off),
    .wr_stat(wr_stat), .half_full(half_full), .almost_full(almost_full)
  );

  dcf_rd_ctrl #(.AW(ADDR_W)) u_rd (
    .clk(rclk), .mrst(rst_r[1]), .prst(rst_r[0]),
    .fwft_sel(fwft_sel), .ren(ren), .rt(rt),
    .wgray_s(wgray_r), .ae_off(ae_off),
    .mem_re(mem_re), .raddr(raddr), .rgray(rgray),
    .fwft_mode(fwft_r), .rd_stat(rd_stat), .almost_empty(almost_empty)
  );

  dcf_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rrst(rst_r[1] | rst_r[0]), .re(mem_re), .raddr(raddr),
    .q(dout)
  );

  AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (rst_r[1] | rst_r[0]) (fwft_r && rd_stat && !ren && !rt) |=> (rd_stat && $stable(dout))) else $error("fall-through word changed without read"); // R10

endmodule

// File: tb/tb_dual_clk_flag_fifo.sv
module tb_dual_clk_flag_fifo;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PLO   = 2;
  localparam int PHI   = 5;

  logic       wclk = 1'b0, rclk = 1'b0;
  logic       mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0, thr_sel = 1'b0;
  logic       wen = 1'b0, load = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
  logic       ren = 1'b0, rt = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       wr_stat, rd_stat, half_full, almost_full, almost_empty;

  int n_chk  = 0;
  int n_fail = 0;

  dual_clk_flag_fifo #(
    .ADDR_W(AW), .DATA_W(9), .PRESET_LO(PLO), .PRESET_HI(PHI)
  ) dut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
    .fwft_sel(fwft_sel), .thr_sel(thr_sel),
    .wen(wen), .din(din), .load(load), .ser_en(ser_en), .ser_in(ser_in),
    .ren(ren), .rt(rt), .dout(dout),
    .wr_stat(wr_stat), .rd_stat(rd_stat), .half_full(half_full),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  // 50 MHz write clock; read clock 28 ns period, phased so edges never coincide
  always #10 wclk = ~wclk;
  initial begin
    #3;
    forever #14 rclk = ~rclk;
  end

  task automatic check(input string msg, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic mreset(input logic fw, input logic sel);
    @(negedge wclk);
    mrst = 1'b1; fwft_sel = fw; thr_sel = sel;
    repeat (6) @(negedge rclk);
    @(negedge wclk);
    mrst = 1'b0;
    settle();
  endtask

  task automatic preset_part();
    @(negedge wclk);
    prst = 1'b1;
    repeat (6) @(negedge rclk);
    @(negedge wclk);
    prst = 1'b0;
    settle();
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge wclk);
    wen = 1'b1; din = d;
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic rd(output logic [8:0] q);
    @(negedge rclk);
    ren = 1'b1;
    @(negedge rclk);
    ren = 1'b0;
    q = dout;
  endtask

  task automatic chk_std(input string ctx, input int n, input int a, input int f);
    check({ctx, " R2 empty"},         int'(rd_stat),      int'(n == 0));
    check({ctx, " R3 full"},          int'(wr_stat),      int'(n == DEPTH));
    check({ctx, " R4 half_full"},     int'(half_full),    int'(n > DEPTH / 2));
    check({ctx, " R5 almost_empty"},  int'(almost_empty), int'(n <= a));
    check({ctx, " R6 almost_full"},   int'(almost_full),  int'(n >= DEPTH - f));
  endtask

  task automatic sweep_std(input string ctx, input int a, input int f, input logic [8:0] base);
    logic [8:0] q;
    for (int n = 0; n <= DEPTH; n++) begin
      if (n > 0) wr(9'(base + n));
      settle();
      chk_std(ctx, n, a, f);
    end
    wr(9'(base + DEPTH + 1));   // ignored while full
    settle();
    check({ctx, " R3 full after extra write"}, int'(wr_stat), 1);
    for (int k = 1; k <= DEPTH; k++) begin
      rd(q);
      check({ctx, " R1 order"}, int'(q), int'(9'(base + k)));
      settle();
      chk_std(ctx, DEPTH - k, a, f);
    end
    rd(q);                      // read while empty
    check({ctx, " R2 empty read holds dout"}, int'(q), int'(9'(base + DEPTH)));
    check({ctx, " R2 still empty"}, int'(rd_stat), 1);
  endtask

  task automatic sweep_fwft(input string ctx, input int a, input int f, input logic [8:0] base);
    int m;
    for (int n = 0; n <= DEPTH + 1; n++) begin
      if (n > 0) wr(9'(base + n));
      settle();
      m = (n > 0) ? n - 1 : 0;
      check({ctx, " R10 out valid"},   int'(rd_stat),      int'(n > 0));
      check({ctx, " R10 input ready"}, int'(wr_stat),      int'(m < DEPTH));
      check({ctx, " R4 half_full"},    int'(half_full),    int'(m > DEPTH / 2));
      check({ctx, " R5 almost_empty"}, int'(almost_empty), int'(n <= a));
      check({ctx, " R6 almost_full"},  int'(almost_full),  int'(m >= DEPTH - f));
    end
    wr(9'(base + DEPTH + 2));   // ignored while not ready
    settle();
    for (int k = 1; k <= DEPTH + 1; k++) begin
      check({ctx, " R10 head word"}, int'(dout), int'(9'(base + k)));
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
      settle();
      check({ctx, " R10 valid after read"}, int'(rd_stat), int'(k < DEPTH + 1));
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] q;
    logic [7:0] sbits;

    // reset state
    mreset(1'b0, 1'b0);
    check("R12 dout cleared", int'(dout), 0);
    check("R12 empty", int'(rd_stat), 1);
    check("R12 not full", int'(wr_stat), 0);
    check("R12 almost_empty", int'(almost_empty), 1);
    check("R12 almost_full", int'(almost_full), 0);
    check("R12 half_full", int'(half_full), 0);

    // standard first-word latency
    @(negedge wclk); wen = 1'b1; din = 9'h1A5;
    @(posedge wclk); #1 wen = 1'b0;
    @(posedge rclk); @(negedge rclk);
    check("R14 std empty after 1 rclk", int'(rd_stat), 1);
    @(posedge rclk); @(negedge rclk);
    check("R14 std not empty after 2 rclk", int'(rd_stat), 0);
    rd(q);
    check("R1 single word", int'(q), 'h1A5);
    settle();

    // presets
    sweep_std("R7 lo", PLO, PLO, 9'h100);
    mreset(1'b0, 1'b1);
    sweep_std("R7 hi", PHI, PHI, 9'h0F0);

    // parallel offset load: empty offset 1, full offset 7
    @(negedge wclk); load = 1'b1; wen = 1'b1; din = 9'd1;
    @(negedge wclk); din = 9'd7;
    @(negedge wclk); wen = 1'b0; load = 1'b0;
    settle();
    check("R8 load stores no data", int'(rd_stat), 1);
    sweep_std("R8", 1, 7, 9'h055);

    // partial reset keeps offsets 1/7
    for (int i = 0; i < 5; i++) wr(9'(i));
    settle();
    preset_part();
    check("R11 emptied", int'(rd_stat), 1);
    sweep_std("R11", 1, 7, 9'h1C0);

    // master reset restores presets
    mreset(1'b0, 1'b0);
    wr(9'd1); wr(9'd2); settle();
    check("R12 preset ae at 2", int'(almost_empty), 1);
    wr(9'd3); settle();
    check("R12 preset ae at 3", int'(almost_empty), 0);

    // serial load: empty offset 6, full offset 3
    mreset(1'b0, 1'b0);
    sbits = {4'd3, 4'd6};
    @(negedge wclk); load = 1'b1; ser_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ser_in = sbits[i];
      @(negedge wclk);
    end
    load = 1'b0; ser_en = 1'b0;
    settle();
    check("R9 shift stores no data", int'(rd_stat), 1);
    sweep_std("R9", 6, 3, 9'h033);

    // standard retransmit
    mreset(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) wr(9'(9'h140 + i));
    settle();
    for (int i = 0; i < 3; i++) begin
      rd(q);
      check("R13 first pass", int'(q), int'(9'(9'h140 + i)));
    end
    @(negedge rclk); rt = 1'b1;
    @(negedge rclk); rt = 1'b0;
    settle();
    for (int i = 0; i < 5; i++) begin
      rd(q);
      check("R13 replay", int'(q), int'(9'(9'h140 + i)));
    end
    settle();
    check("R13 empty after replay", int'(rd_stat), 1);

    // fall-through mode
    mreset(1'b1, 1'b0);
    check("R10 reset ready", int'(wr_stat), 1);
    check("R10 reset not valid", int'(rd_stat), 0);
    @(negedge wclk); wen = 1'b1; din = 9'h0C3;
    @(posedge wclk); #1 wen = 1'b0;
    @(posedge rclk); @(negedge rclk);
    @(posedge rclk); @(negedge rclk);
    check("R14 fwft not valid after 2 rclk", int'(rd_stat), 0);
    @(posedge rclk); @(negedge rclk);
    check("R14 fwft valid after 3 rclk", int'(rd_stat), 1);
    check("R10 word without read", int'(dout), 'h0C3);
    repeat (4) @(negedge rclk);
    check("R10 word held", int'(dout), 'h0C3);
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
    settle();
    check("R10 valid drops", int'(rd_stat), 0);
    sweep_fwft("R10", PLO, PLO, 9'h0AA);

    // partial reset keeps fall-through mode
    wr(9'h011); settle();
    preset_part();
    check("R11 fwft emptied", int'(rd_stat), 0);
    wr(9'h1E0); settle();
    check("R11 mode kept", int'(rd_stat), 1);
    check("R11 mode kept word", int'(dout), 'h1E0);

    // fall-through retransmit
    for (int i = 1; i < 4; i++) wr(9'(9'h1E0 + i));
    settle();
    for (int i = 0; i < 2; i++) begin
      check("R13 fwft first pass", int'(dout), int'(9'(9'h1E0 + i)));
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
    end
    @(negedge rclk); rt = 1'b1;
    @(negedge rclk); rt = 1'b0;
    check("R13 fwft valid cleared", int'(rd_stat), 0);
    @(negedge rclk);
    check("R13 fwft valid back", int'(rd_stat), 1);
    check("R13 fwft head replay", int'(dout), 'h1E0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule